// File: doc/BRIEF.md
# GPIO Port Edge/Level Interrupt Controller

This block watches eight general-purpose input lines of one port and turns selected activity on them into a single interrupt request. Each line has its own detection sense, set by two configuration bit-planes. One plane chooses edge or level detection. The other chooses the polarity: rising or active-high, against falling or active-low. A line may also pass through a slow debounce filter before detection.

Edge events are caught in a per-line latch. The latch holds the event until software writes a one to that line's bit in the acknowledge register. Level-sensed lines report the present input state and need no acknowledge. Software reaches the unit through a byte-wide register bus. Writes take effect on a single-cycle write strobe, and read data is a combinational function of the address. Two status views are offered: a raw view that ignores the enable plane, and a masked view that the interrupt output is built from.

The bus is a plain register interface with no flow control. A write is accepted on every clock edge where `bus_wr` is high, and reads never stall. Software must clear a line's enable bit before it changes that line's mode or polarity, then set the enable again.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the mode, polarity, enable and debounce registers read 0, the masked status reads 0, and `irq_out` is low.
- R2: Register offsets are fixed as follows. Mode is at 0x00, polarity at 0x04, acknowledge at 0x08, enable at 0x0C, masked status at 0x10, raw status at 0x14 and debounce enable at 0x18. The writable registers (mode, polarity, enable, debounce) read back what was written, and the acknowledge offset reads 0.
- R3: A line with mode bit 1 and polarity bit 1 latches a pending event on a 0-to-1 transition of its input. The event stays latched without any acknowledge.
- R4: A line with mode bit 1 and polarity bit 0 latches a pending event on a 1-to-0 transition of its input.
- R5: A line with mode bit 0 and polarity bit 1 is pending exactly while its input is 1. Acknowledge writes do not change its status.
- R6: A line with mode bit 0 and polarity bit 0 is pending exactly while its input is 0.
- R7: Writing a byte to the acknowledge offset clears the latched event of every line whose bit is 1 and leaves the other lines' latches intact.
- R8: Masked status equals raw status ANDed with the enable register, and `irq_out` is high exactly when any masked status bit is 1.
- R9: Raw status shows latched edges and active levels whatever the enable bits are. After reset, with all inputs at 0, it reads 0xFF, because every line defaults to active-low level sensing.
- R10: For a line whose debounce bit is 1, the filtered value takes a new input level only on the fourth consecutive `deb_tick` during which the synchronised input has held that level. A shorter excursion is ignored.
- R11: Debounce applies per line: a line whose debounce bit is 0 responds without any `deb_tick`, even while other lines are filtered.
- R12: Writes to the masked status and raw status offsets change no register and no latch.
- R13: Each input passes two synchronising flops. A rising edge on an edge-mode line appears in raw status after the third rising clock edge following the input change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deb_tick | input | 1 | Slow clock-enable pacing the debounce filters |
| pin_in | input | 8 | Asynchronous GPIO input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The sense logic is tried with a set of configuration and input vectors:
- all lines rising, all lines falling, all lines high-level and all lines low-level, each with a byte pattern that mixes set and clear bits, so that a swapped polarity or a swapped mode plane shows up as a wrong status byte;
- a mixed vector that gives each nibble pair a different sense in one pass;
- a vector with a partial enable, which separates raw status from masked status;
- a vector with no transition, which exposes spurious edges.

Directed runs then cover the following:
- a split acknowledge, which shows that clearing is per bit;
- level lines under acknowledge;
- the exact synchroniser latency;
- a debounced line beside an unfiltered one, driven with full-length and short excursions, so that a filter counting too few or too many ticks, or failing to restart, is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 5;

  // Register byte offsets decoded by software
  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_POL  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_DEB  = 5'h18;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  raw,
  input  logic [LINES-1:0]  stat,
  output logic [LINES-1:0]  mode,
  output logic [LINES-1:0]  pol,
  output logic [LINES-1:0]  ena,
  output logic [LINES-1:0]  deb,
  output logic [LINES-1:0]  ack_mask,
  output logic [LINES-1:0]  rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      pol  <= '0;
      ena  <= '0;
      deb  <= '0;
    end else if (wr) begin
      case (addr)
        OFS_MODE: mode <= wdata;
        OFS_POL:  pol  <= wdata;
        OFS_ENA:  ena  <= wdata;
        OFS_DEB:  deb  <= wdata;
        default:  ;
      endcase
    end
  end

  // Acknowledge is a write-one strobe, never stored
  assign ack_mask = (wr && addr == OFS_ACK) ? wdata : '0;

  always_comb begin
    case (addr)
      OFS_MODE: rdata = mode;
      OFS_POL:  rdata = pol;
      OFS_ENA:  rdata = ena;
      OFS_DEB:  rdata = deb;
      OFS_STAT: rdata = stat;
      OFS_RAW:  rdata = raw;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  input  logic deb_on,
  output logic filt_q,
  output logic val
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_TICKS - 1);

  logic [SYNC_STAGES-1:0] sh_q;
  logic                   sync;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-2:0], pin};
  end
  assign sync = sh_q[SYNC_STAGES-1];

  // Filtered level moves only after DEB_TICKS ticks of a stable new level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sync == filt_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == CNT_LAST) begin
        filt_q <= sync;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign val = deb_on ? filt_q : sync;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] val,
  input  logic [LINES-1:0] mode,
  input  logic [LINES-1:0] pol,
  input  logic [LINES-1:0] ena,
  input  logic [LINES-1:0] ack_mask,
  output logic [LINES-1:0] hit,
  output logic [LINES-1:0] lat,
  output logic [LINES-1:0] raw,
  output logic [LINES-1:0] stat
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] rise, fall, lvl_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= val;
  end

  assign rise    = val & ~prev_q;
  assign fall    = ~val & prev_q;
  assign hit     = mode & ((pol & rise) | (~pol & fall));
  assign lvl_act = ~(val ^ pol);

  // A new event wins over an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else        lat <= (lat & ~ack_mask) | hit;
  end

  assign raw  = (mode & lat) | (~mode & lvl_act);
  assign stat = raw & ena;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deb_tick,
  input  logic [LINES-1:0]  pin_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  output logic              irq_out
);
  logic [LINES-1:0] mode_q, pol_q, ena_q, deb_q, ack_mask;
  logic [LINES-1:0] line_val, deb_state;
  logic [LINES-1:0] edge_hit, edge_lat, raw_stat, msk_stat;

  gpio_irq_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .raw(raw_stat), .stat(msk_stat), .mode(mode_q), .pol(pol_q), .ena(ena_q),
    .deb(deb_q), .ack_mask(ack_mask), .rdata(bus_rdata)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    gpio_irq_front #(.SYNC_STAGES(SYNC_STAGES), .DEB_TICKS(DEB_TICKS)) u_front (
      .clk(clk), .rst_n(rst_n), .tick(deb_tick), .pin(pin_in[i]),
      .deb_on(deb_q[i]), .filt_q(deb_state[i]), .val(line_val[i])
    );
  end

  gpio_irq_detect #(.LINES(LINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .val(line_val), .mode(mode_q), .pol(pol_q),
    .ena(ena_q), .ack_mask(ack_mask), .hit(edge_hit), .lat(edge_lat),
    .raw(raw_stat), .stat(msk_stat)
  );

  assign irq_out = |msk_stat;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic             deb_tick,
  input logic [LINES-1:0] ena,
  input logic [LINES-1:0] lat,
  input logic [LINES-1:0] hit,
  input logic [LINES-1:0] ack,
  input logic [LINES-1:0] filt
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!irq_out); // R1
    end
  end

  AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ena != '0)); // R8

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack == '0) |=> (($past(lat) & ~lat) == '0)); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((lat & $past(ack) & ~$past(hit)) == '0)); // R7

  AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !deb_tick |=> $stable(filt)); // R10
endmodule

bind gpio_irq_unit gpio_irq_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .deb_tick(deb_tick),
  .ena(ena_q), .lat(edge_lat), .hit(edge_hit), .ack(ack_mask), .filt(deb_state)
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;
  import gpio_irq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       deb_tick = 1'b0;
  logic [7:0] pins = '0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .deb_tick(deb_tick), .pin_in(pins),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {mode, pol, ena, pins_before, pins_after, expected masked status}
  localparam logic [47:0] VEC [7] = '{
    {8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hA5, 8'hA5},  // R3 rising
    {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h3C, 8'hC3},  // R4 falling
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h5A, 8'h5A},  // R5 high level
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'hF0},  // R6 low level
    {8'hF0, 8'hCC, 8'hFF, 8'h00, 8'hFF, 8'hCC},  // R8 mixed senses
    {8'hFF, 8'hFF, 8'h0F, 8'h00, 8'hA5, 8'h05},  // R8 partial enable
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00}   // R3 no transition
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pins = p;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); deb_tick = 1'b1;
      @(negedge clk); deb_tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3);
    // R1 reset state
    @(negedge clk);
    rd(OFS_MODE, d); chk("R1 mode", d, 8'h00);
    rd(OFS_POL,  d); chk("R1 pol",  d, 8'h00);
    rd(OFS_ENA,  d); chk("R1 ena",  d, 8'h00);
    rd(OFS_DEB,  d); chk("R1 deb",  d, 8'h00);
    rd(OFS_STAT, d); chk("R1 stat", d, 8'h00);
    chk("R1 irq", {7'd0, irq_out}, 8'h00);
    rst_n = 1'b1;
    idle(4);
    rd(OFS_RAW, d); chk("R9 raw after reset", d, 8'hFF);
    chk("R1 irq after release", {7'd0, irq_out}, 8'h00);

    // R2 map and readback
    wr(OFS_MODE, 8'h3A); wr(OFS_POL, 8'hC5); wr(OFS_ENA, 8'h81); wr(OFS_DEB, 8'h42);
    rd(OFS_MODE, d); chk("R2 mode", d, 8'h3A);
    rd(OFS_POL,  d); chk("R2 pol",  d, 8'hC5);
    rd(OFS_ENA,  d); chk("R2 ena",  d, 8'h81);
    rd(OFS_DEB,  d); chk("R2 deb",  d, 8'h42);
    rd(OFS_ACK,  d); chk("R2 ack reads 0", d, 8'h00);
    wr(OFS_ENA, 8'h00); wr(OFS_DEB, 8'h00);

    // Vector table
    for (int i = 0; i < 7; i++) begin
      wr(OFS_ENA, 8'h00);
      wr(OFS_MODE, VEC[i][47:40]);
      wr(OFS_POL,  VEC[i][39:32]);
      set_pins(VEC[i][23:16]);
      idle(5);
      wr(OFS_ACK, 8'hFF);
      wr(OFS_ENA, VEC[i][31:24]);
      set_pins(VEC[i][15:8]);
      idle(5);
      rd(OFS_STAT, d); chk($sformatf("R3-vector %0d status (R8)", i), d, VEC[i][7:0]);
      chk($sformatf("R8 vector %0d irq", i), {7'd0, irq_out}, {7'd0, |VEC[i][7:0]});
    end

    // R13 synchroniser latency
    wr(OFS_ENA, 8'h00); wr(OFS_MODE, 8'hFF); wr(OFS_POL, 8'hFF);
    set_pins(8'h00); idle(5); wr(OFS_ACK, 8'hFF);
    @(negedge clk); pins = 8'h01;
    idle(2); rd(OFS_RAW, d); chk("R13 not after 2 edges", d, 8'h00);
    idle(1); rd(OFS_RAW, d); chk("R13 after 3 edges", d, 8'h01);

    // R9 raw ignores enable, R7 partial acknowledge
    set_pins(8'hFF); idle(5);
    rd(OFS_RAW, d);  chk("R9 raw with ena 0", d, 8'hFF);
    rd(OFS_STAT, d); chk("R8 stat with ena 0", d, 8'h00);
    chk("R8 irq with ena 0", {7'd0, irq_out}, 8'h00);
    // R12 writes to status offsets ignored
    wr(OFS_STAT, 8'h00); wr(OFS_RAW, 8'h00);
    rd(OFS_RAW, d);  chk("R12 raw kept", d, 8'hFF);
    rd(OFS_MODE, d); chk("R12 mode kept", d, 8'hFF);
    wr(OFS_ENA, 8'hFF);
    wr(OFS_ACK, 8'h0F);
    rd(OFS_STAT, d); chk("R7 partial ack", d, 8'hF0);
    chk("R8 irq partial", {7'd0, irq_out}, 8'h01);
    wr(OFS_ACK, 8'hF0);
    rd(OFS_STAT, d); chk("R7 full ack", d, 8'h00);

    // R5 level lines ignore acknowledge
    wr(OFS_ENA, 8'h00); wr(OFS_MODE, 8'h00); wr(OFS_POL, 8'hFF);
    set_pins(8'h33); idle(4); wr(OFS_ENA, 8'hFF);
    rd(OFS_STAT, d); chk("R5 level", d, 8'h33);
    wr(OFS_ACK, 8'hFF);
    rd(OFS_STAT, d); chk("R5 level after ack", d, 8'h33);

    // R10 / R11 debounce on line 0 only, both high-level
    wr(OFS_ENA, 8'h00); set_pins(8'h00); idle(4);
    wr(OFS_POL, 8'h03); wr(OFS_DEB, 8'h01); wr(OFS_ENA, 8'h03);
    rd(OFS_STAT, d); chk("R10 idle", d, 8'h00);
    set_pins(8'h03); idle(4);
    rd(OFS_STAT, d); chk("R11 unfiltered line", d, 8'h02);
    tick(3); rd(OFS_STAT, d); chk("R10 three ticks", d, 8'h02);
    tick(1); rd(OFS_STAT, d); chk("R10 fourth tick", d, 8'h03);
    set_pins(8'h02); idle(4); tick(2);
    set_pins(8'h03); idle(4); tick(2);
    rd(OFS_STAT, d); chk("R10 short glitch", d, 8'h03);
    set_pins(8'h02); idle(4); tick(3);
    rd(OFS_STAT, d); chk("R10 fall three ticks", d, 8'h03);
    tick(1); rd(OFS_STAT, d); chk("R10 fall fourth tick", d, 8'h02);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule